// File: doc/BRIEF.md
# Floating-Point Register Stack Controller

This block keeps the eight-slot circular operand stack of a floating-point coprocessor. The stack pointer is held in a 3-bit field of a 16-bit status word. Each physical slot carries a 2-bit tag that marks it as holding a normal value, a zero, a special value, or nothing. Payloads are opaque 64-bit words. The block does no arithmetic. A datapath sends one command per cycle to push, push zero, pop, read or write a stack-relative operand ST(i), or to load or fetch the status and control words.

ST(i) is reached through a 3-bit relative index. A push that lands on an occupied slot is blocked and sets a sticky stack-fault flag with an overflow direction. A pop, read or write-then-pop that touches an empty top slot sets the same flag with an underflow direction. A blocked command leaves the stack untouched.

Top module: `fpstk_ctrl`

## Requirements
- R1: After reset every tag is Empty (tag codes: 2'b00 Valid, 2'b01 Zero, 2'b10 Special, 2'b11 Empty; slot k occupies `tag_vec[2k+1:2k]`). The status word is 16'h0000 and the control word is 16'h037F.
- R2: ST(i) is the physical slot (TOP + i) mod 8. A read (op 4'd4) presents that slot's data on `rd_data` and its tag on `rd_tag`, with `rd_valid` high, one cycle after the command.
- R3: A push (op 4'd1) decrements TOP mod 8, stores `cmd_data` in the new top slot and tags it Valid. If that slot is not Empty, nothing in the stack changes, and status bit 6 (stack fault) and bit 9 (1 = overflow) are set.
- R4: A zero push (op 4'd2) acts like a push, but it stores 0 and tags the slot Zero. It takes the same overflow check as R3.
- R5: A pop (op 4'd3) tags the top slot Empty and increments TOP mod 8, leaving the slot's data as it was. If the top slot is already Empty, nothing changes, and bit 6 is set with bit 9 cleared (underflow).
- R6: A write (op 4'd5) stores `cmd_data` in ST(i) and tags it Zero when the data is 0, otherwise Valid. TOP does not move.
- R7: A write-then-pop (op 4'd6) writes ST(i) as in R6 and then pops, so the result sits at ST(i-1) of the new TOP. If the top slot is Empty when the command arrives, the whole command is dropped with an underflow fault.
- R8: TOP lives in status bits 13:11. A status load (op 4'd7) replaces the whole status word with `cmd_data[15:0]`. A status fetch (op 4'd9) returns the whole word on `sw_data`, with `sw_valid` high, one cycle later.
- R9: A control load (op 4'd8) sets the control word from `cmd_data[15:0]`. `round_mode` shows bits 9:8 (0 nearest, 1 down, 2 up, 3 truncate) and `exc_mask` shows bits 5:0.
- R10: A read of an Empty ST(i) still returns the slot's data and tag, and raises an underflow fault (bit 6 set, bit 9 cleared).
- R11: An initialize command (op 4'd10) sets all tags to Empty, the status word to 0 and the control word to 16'h037F. The slot data is left as it was.
- R12: The stack-fault flag stays set until a status load or an initialize command clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_ready | output | 1 | Block accepts a command (always high) |
| cmd_op | input | 4 | Command code |
| cmd_idx | input | 3 | Stack-relative index i of ST(i) |
| cmd_data | input | 64 | Payload for push, write, or status/control load |
| rd_valid | output | 1 | Read result present |
| rd_data | output | 64 | Data read from ST(i) |
| rd_tag | output | 2 | Tag read from ST(i) |
| sw_valid | output | 1 | Status fetch result present |
| sw_data | output | 16 | Fetched status word |
| ctl_word | output | 16 | Current control word |
| round_mode | output | 2 | Rounding mode field of the control word |
| exc_mask | output | 6 | Exception mask field of the control word |
| tag_vec | output | 16 | All eight slot tags, slot k at bits 2k+1:2k |
| stack_fault | output | 1 | Sticky stack-fault flag (status bit 6) |

## Verification
A command is captured on one rising edge. On that same edge the tags, TOP, control word and fault flag take their new values. The read result and the status-fetch result are registered outputs and are due one edge after capture, for the single cycle that follows. The bench drives each command on a falling edge and drops it on the next falling edge, just after the capturing edge. It compares every output there, before the next command is issued. A reference stack model is updated once per command and supplies the expected tags, TOP, data and fault bits.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;

    localparam int NSLOT    = 8;
    localparam int PTR_W    = $clog2(NSLOT);
    localparam int TAG_W    = 2;
    localparam int DATA_W   = 64;
    localparam int WORD_W   = 16;

    localparam int SW_TOP_LSB = 11;
    localparam int SW_SF_BIT  = 6;
    localparam int SW_DIR_BIT = 9;
    localparam logic [WORD_W-1:0] CW_RESET = 16'h037F;

    localparam logic [TAG_W-1:0] TAG_VALID   = 2'b00;
    localparam logic [TAG_W-1:0] TAG_ZERO    = 2'b01;
    localparam logic [TAG_W-1:0] TAG_SPECIAL = 2'b10;
    localparam logic [TAG_W-1:0] TAG_EMPTY   = 2'b11;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_PUSH  = 4'd1,
        OP_PUSHZ = 4'd2,
        OP_POP   = 4'd3,
        OP_READ  = 4'd4,
        OP_WRITE = 4'd5,
        OP_WRPOP = 4'd6,
        OP_LDSW  = 4'd7,
        OP_LDCW  = 4'd8,
        OP_STSW  = 4'd9,
        OP_INIT  = 4'd10
    } op_e;

endpackage

// File: rtl/fpstk_regfile.sv
module fpstk_regfile #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] mem_d [DEPTH];

    always_comb begin
        for (int k = 0; k < DEPTH; k++) begin
            mem_d[k] = mem_q[k];
        end
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else begin
                mem_q[g] <= mem_d[g];
            end
        end
    end

    assign rdata = mem_q[raddr];

    // R6: a written slot holds the written data on the next cycle
    p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem_q[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/fpstk_tags.sv
module fpstk_tags
    import fpstk_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   init,
    input  logic                   we_a,
    input  logic [AW-1:0]          addr_a,
    input  logic [TAG_W-1:0]       tag_a,
    input  logic                   we_b,
    input  logic [AW-1:0]          addr_b,
    input  logic [TAG_W-1:0]       tag_b,
    output logic [DEPTH*TAG_W-1:0] tag_vec
);

    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [TAG_W-1:0] tag_d [DEPTH];

    always_comb begin
        for (int k = 0; k < DEPTH; k++) begin
            tag_d[k] = tag_q[k];
        end
        if (init) begin
            for (int k = 0; k < DEPTH; k++) begin
                tag_d[k] = TAG_EMPTY;
            end
        end else begin
            if (we_a) tag_d[addr_a] = tag_a;
            if (we_b) tag_d[addr_b] = tag_b;   // pop port wins on a shared slot
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_tag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tag_q[g] <= TAG_EMPTY;
            end else begin
                tag_q[g] <= tag_d[g];
            end
        end
        assign tag_vec[g*TAG_W +: TAG_W] = tag_q[g];
    end

    // R11: initialization empties every slot
    p_init_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (&tag_vec));

endmodule

// File: rtl/fpstk_ctrl.sv
module fpstk_ctrl
    import fpstk_pkg::*;
#(
    parameter int DW = fpstk_pkg::DATA_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    output logic                   cmd_ready,
    input  logic [3:0]             cmd_op,
    input  logic [PTR_W-1:0]       cmd_idx,
    input  logic [DW-1:0]          cmd_data,
    output logic                   rd_valid,
    output logic [DW-1:0]          rd_data,
    output logic [TAG_W-1:0]       rd_tag,
    output logic                   sw_valid,
    output logic [WORD_W-1:0]      sw_data,
    output logic [WORD_W-1:0]      ctl_word,
    output logic [1:0]             round_mode,
    output logic [5:0]             exc_mask,
    output logic [NSLOT*TAG_W-1:0] tag_vec,
    output logic                   stack_fault
);

    typedef struct packed {
        logic [WORD_W-1:0] sw;
        logic [WORD_W-1:0] cw;
        logic              rd_valid;
        logic [DW-1:0]     rd_data;
        logic [TAG_W-1:0]  rd_tag;
        logic              sw_valid;
        logic [WORD_W-1:0] sw_out;
    } state_t;

    state_t st_q, st_d;

    logic [PTR_W-1:0] top_q, top_dn, top_up, phys_i;
    logic [TAG_W-1:0] tag_top, tag_dn, tag_i;
    logic             fire;

    logic             rf_we;
    logic [PTR_W-1:0] rf_waddr;
    logic [DW-1:0]    rf_wdata, rf_rdata;

    logic             tg_init, tg_we_a, tg_we_b;
    logic [PTR_W-1:0] tg_addr_a, tg_addr_b;
    logic [TAG_W-1:0] tg_tag_a, tg_tag_b;

    function automatic logic [WORD_W-1:0] put_top(input logic [WORD_W-1:0] sw,
                                                  input logic [PTR_W-1:0]  t);
        logic [WORD_W-1:0] r;
        r = sw;
        r[SW_TOP_LSB +: PTR_W] = t;
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] put_fault(input logic [WORD_W-1:0] sw,
                                                    input logic overflow);
        logic [WORD_W-1:0] r;
        r = sw;
        r[SW_SF_BIT]  = 1'b1;
        r[SW_DIR_BIT] = overflow;
        return r;
    endfunction

    assign cmd_ready = 1'b1;
    assign fire      = cmd_valid && cmd_ready;
    assign top_q     = st_q.sw[SW_TOP_LSB +: PTR_W];
    assign top_dn    = top_q - 1'b1;
    assign top_up    = top_q + 1'b1;
    assign phys_i    = top_q + cmd_idx;
    assign tag_top   = tag_vec[top_q  * TAG_W +: TAG_W];
    assign tag_dn    = tag_vec[top_dn * TAG_W +: TAG_W];
    assign tag_i     = tag_vec[phys_i * TAG_W +: TAG_W];

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = 1'b0;
        st_d.sw_valid = 1'b0;
        rf_we         = 1'b0;
        rf_waddr      = phys_i;
        rf_wdata      = cmd_data;
        tg_init       = 1'b0;
        tg_we_a       = 1'b0;
        tg_addr_a     = phys_i;
        tg_tag_a      = TAG_VALID;
        tg_we_b       = 1'b0;
        tg_addr_b     = top_q;
        tg_tag_b      = TAG_EMPTY;

        if (fire) begin
            case (op_e'(cmd_op))
                OP_PUSH, OP_PUSHZ: begin
                    if (tag_dn != TAG_EMPTY) begin
                        st_d.sw = put_fault(st_q.sw, 1'b1);
                    end else begin
                        st_d.sw   = put_top(st_q.sw, top_dn);
                        rf_we     = 1'b1;
                        rf_waddr  = top_dn;
                        rf_wdata  = (cmd_op == OP_PUSHZ) ? '0 : cmd_data;
                        tg_we_a   = 1'b1;
                        tg_addr_a = top_dn;
                        tg_tag_a  = (cmd_op == OP_PUSHZ) ? TAG_ZERO : TAG_VALID;
                    end
                end
                OP_POP: begin
                    if (tag_top == TAG_EMPTY) begin
                        st_d.sw = put_fault(st_q.sw, 1'b0);
                    end else begin
                        st_d.sw = put_top(st_q.sw, top_up);
                        tg_we_b = 1'b1;
                    end
                end
                OP_READ: begin
                    st_d.rd_valid = 1'b1;
                    st_d.rd_data  = rf_rdata;
                    st_d.rd_tag   = tag_i;
                    if (tag_i == TAG_EMPTY) begin
                        st_d.sw = put_fault(st_q.sw, 1'b0);
                    end
                end
                OP_WRITE: begin
                    rf_we    = 1'b1;
                    tg_we_a  = 1'b1;
                    tg_tag_a = (cmd_data == '0) ? TAG_ZERO : TAG_VALID;
                end
                OP_WRPOP: begin
                    if (tag_top == TAG_EMPTY) begin
                        st_d.sw = put_fault(st_q.sw, 1'b0);
                    end else begin
                        rf_we    = 1'b1;
                        tg_we_a  = 1'b1;
                        tg_tag_a = (cmd_data == '0) ? TAG_ZERO : TAG_VALID;
                        tg_we_b  = 1'b1;
                        st_d.sw  = put_top(st_q.sw, top_up);
                    end
                end
                OP_LDSW: st_d.sw = cmd_data[WORD_W-1:0];
                OP_LDCW: st_d.cw = cmd_data[WORD_W-1:0];
                OP_STSW: begin
                    st_d.sw_valid = 1'b1;
                    st_d.sw_out   = st_q.sw;
                end
                OP_INIT: begin
                    tg_init = 1'b1;
                    st_d.sw = '0;
                    st_d.cw = CW_RESET;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.cw     <= CW_RESET;
        end else begin
            st_q        <= st_d;
        end
    end

    fpstk_regfile #(.DEPTH(NSLOT), .WIDTH(DW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .raddr (phys_i),
        .rdata (rf_rdata)
    );

    fpstk_tags #(.DEPTH(NSLOT)) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (tg_init),
        .we_a    (tg_we_a),
        .addr_a  (tg_addr_a),
        .tag_a   (tg_tag_a),
        .we_b    (tg_we_b),
        .addr_b  (tg_addr_b),
        .tag_b   (tg_tag_b),
        .tag_vec (tag_vec)
    );

    assign rd_valid    = st_q.rd_valid;
    assign rd_data     = st_q.rd_data;
    assign rd_tag      = st_q.rd_tag;
    assign sw_valid    = st_q.sw_valid;
    assign sw_data     = st_q.sw_out;
    assign ctl_word    = st_q.cw;
    assign round_mode  = st_q.cw[9:8];
    assign exc_mask    = st_q.cw[5:0];
    assign stack_fault = st_q.sw[SW_SF_BIT];

    // R3: a push onto an empty slot moves TOP down by one and tags it Valid
    p_push_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_PUSH && tag_dn == TAG_EMPTY)
        |=> (top_q == PTR_W'($past(top_q) - 1'b1)) && (tag_top == TAG_VALID));

    // R3: overflow leaves pointer and tags untouched and flags the fault
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_PUSH && tag_dn != TAG_EMPTY)
        |=> $stable(tag_vec) && (top_q == $past(top_q)) && stack_fault);

    // R5: a legal pop moves TOP up by one and empties the old top
    p_pop_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_POP && tag_top != TAG_EMPTY)
        |=> (top_q == PTR_W'($past(top_q) + 1'b1))
            && (tag_vec[$past(top_q) * TAG_W +: TAG_W] == TAG_EMPTY));

    // R2: read results only follow a read command
    p_rd_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(cmd_valid && cmd_op == OP_READ));

    // R12: the fault flag holds until a status load or initialize
    p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (stack_fault && !(cmd_valid && (cmd_op == OP_LDSW || cmd_op == OP_INIT)))
        |=> stack_fault);

endmodule

// File: tb/fpstk_ctrl_tb.sv
`timescale 1ns/1ps
module fpstk_ctrl_tb;

    localparam logic [3:0] PUSH = 4'd1, PUSHZ = 4'd2, POP = 4'd3, READ = 4'd4,
                           WRITE = 4'd5, WRPOP = 4'd6, LDSW = 4'd7, LDCW = 4'd8,
                           STSW = 4'd9, INIT = 4'd10;
    localparam int NV = 32;

    localparam logic [70:0] VEC [NV] = '{
        {PUSH, 3'd0, 64'h0000_0000_0000_1001}, {PUSH, 3'd0, 64'h0000_0000_0000_1002},
        {PUSH, 3'd0, 64'h0000_0000_0000_1003}, {PUSH, 3'd0, 64'h0000_0000_0000_1004},
        {PUSH, 3'd0, 64'h0000_0000_0000_1005}, {PUSH, 3'd0, 64'h0000_0000_0000_1006},
        {PUSH, 3'd0, 64'h0000_0000_0000_1007}, {PUSH, 3'd0, 64'hFEDC_BA98_7654_3210},
        {PUSH, 3'd0, 64'h0000_0000_0000_DEAD}, {STSW, 3'd0, 64'd0},
        {LDSW, 3'd0, 64'd0},                   {READ, 3'd0, 64'd0},
        {READ, 3'd3, 64'd0},                   {READ, 3'd7, 64'd0},
        {WRITE, 3'd2, 64'd0},                  {READ, 3'd2, 64'd0},
        {WRITE, 3'd5, 64'h0000_0000_0000_ABCD},{READ, 3'd5, 64'd0},
        {POP, 3'd0, 64'd0}, {POP, 3'd0, 64'd0}, {POP, 3'd0, 64'd0}, {POP, 3'd0, 64'd0},
        {POP, 3'd0, 64'd0}, {POP, 3'd0, 64'd0}, {POP, 3'd0, 64'd0}, {POP, 3'd0, 64'd0},
        {POP, 3'd0, 64'd0},                    {STSW, 3'd0, 64'd0},
        {READ, 3'd0, 64'd0},                   {PUSHZ, 3'd0, 64'h5555},
        {READ, 3'd0, 64'd0},                   {STSW, 3'd0, 64'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [3:0]  cmd_op = '0;
    logic [2:0]  cmd_idx = '0;
    logic [63:0] cmd_data = '0;
    logic        rd_valid, sw_valid, stack_fault;
    logic [63:0] rd_data;
    logic [1:0]  rd_tag, round_mode;
    logic [15:0] sw_data, ctl_word, tag_vec;
    logic [5:0]  exc_mask;

    int checks = 0;
    int failures = 0;

    logic [63:0] m_reg [8];
    logic [1:0]  m_tag [8];
    logic [15:0] m_sw, m_cw;
    logic [63:0] e_rd;
    logic [1:0]  e_rdtag;
    logic [15:0] e_sw;

    always #2.5 clk = ~clk;

    fpstk_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_data(cmd_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_tag(rd_tag),
        .sw_valid(sw_valid), .sw_data(sw_data), .ctl_word(ctl_word),
        .round_mode(round_mode), .exc_mask(exc_mask), .tag_vec(tag_vec),
        .stack_fault(stack_fault)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] m_tags_packed();
        logic [15:0] v;
        for (int k = 0; k < 8; k++) v[2*k +: 2] = m_tag[k];
        return v;
    endfunction

    function automatic string req_of(input logic [3:0] op);
        case (op)
            PUSH:  return "R3";
            PUSHZ: return "R4";
            POP:   return "R5";
            READ:  return "R2";
            WRITE: return "R6";
            WRPOP: return "R7";
            LDCW:  return "R9";
            INIT:  return "R11";
            default: return "R8";
        endcase
    endfunction

    task automatic m_fault(input bit ovf);
        m_sw[6] = 1'b1;
        m_sw[9] = ovf;
    endtask

    // reference stack model, applied once per command
    task automatic m_apply(input logic [3:0] op, input logic [2:0] idx, input logic [63:0] d);
        logic [2:0] t, tn, pi;
        t  = m_sw[13:11];
        tn = t - 3'd1;
        pi = t + idx;
        case (op)
            PUSH, PUSHZ: begin
                if (m_tag[tn] != 2'b11) m_fault(1'b1);
                else begin
                    m_sw[13:11] = tn;
                    m_reg[tn]   = (op == PUSHZ) ? 64'd0 : d;
                    m_tag[tn]   = (op == PUSHZ) ? 2'b01 : 2'b00;
                end
            end
            POP: begin
                if (m_tag[t] == 2'b11) m_fault(1'b0);
                else begin m_tag[t] = 2'b11; m_sw[13:11] = t + 3'd1; end
            end
            READ: begin
                e_rd = m_reg[pi]; e_rdtag = m_tag[pi];
                if (m_tag[pi] == 2'b11) m_fault(1'b0);
            end
            WRITE: begin
                m_reg[pi] = d; m_tag[pi] = (d == 0) ? 2'b01 : 2'b00;
            end
            WRPOP: begin
                if (m_tag[t] == 2'b11) m_fault(1'b0);
                else begin
                    m_reg[pi] = d; m_tag[pi] = (d == 0) ? 2'b01 : 2'b00;
                    m_tag[t] = 2'b11; m_sw[13:11] = t + 3'd1;
                end
            end
            LDSW: m_sw = d[15:0];
            LDCW: m_cw = d[15:0];
            STSW: e_sw = m_sw;
            INIT: begin
                for (int k = 0; k < 8; k++) m_tag[k] = 2'b11;
                m_sw = 16'h0; m_cw = 16'h037F;
            end
            default: ;
        endcase
    endtask

    // drive on a falling edge, capture on the next rising edge, compare on the falling edge after it
    task automatic do_cmd(input logic [3:0] op, input logic [2:0] idx, input logic [63:0] d);
        string r;
        r = req_of(op);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx; cmd_data = d;
        m_apply(op, idx, d);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 4'd0;
        chk(tag_vec == m_tags_packed(), {r, " tags"}, 64'(tag_vec), 64'(m_tags_packed()));
        chk(stack_fault == m_sw[6], "R12 fault flag", 64'(stack_fault), 64'(m_sw[6]));
        chk(ctl_word == m_cw && round_mode == m_cw[9:8] && exc_mask == m_cw[5:0],
            "R9 control fields", 64'(ctl_word), 64'(m_cw));
        if (op == READ) begin
            chk(rd_valid && rd_data == e_rd, (e_rdtag == 2'b11) ? "R10 read data" : "R2 read data",
                rd_data, e_rd);
            chk(rd_tag == e_rdtag, (e_rdtag == 2'b11) ? "R10 read tag" : "R2 read tag",
                64'(rd_tag), 64'(e_rdtag));
        end else begin
            chk(!rd_valid, "R2 no stray read", 64'(rd_valid), 64'd0);
        end
        if (op == STSW) begin
            chk(sw_valid && sw_data == e_sw, "R8 status word", 64'(sw_data), 64'(e_sw));
        end
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++) begin m_reg[k] = '0; m_tag[k] = 2'b11; end
        m_sw = 16'h0; m_cw = 16'h037F; e_rd = '0; e_rdtag = '0; e_sw = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(tag_vec == 16'hFFFF, "R1 tags empty", 64'(tag_vec), 64'hFFFF);
        chk(ctl_word == 16'h037F, "R1 control word", 64'(ctl_word), 64'h037F);
        chk(!stack_fault && !rd_valid && !sw_valid, "R1 flags", 64'(stack_fault), 64'd0);
        chk(cmd_ready, "R1 ready", 64'(cmd_ready), 64'd1);
        do_cmd(STSW, 3'd0, 64'd0);

        for (int v = 0; v < NV; v++) begin
            do_cmd(VEC[v][70:67], VEC[v][66:64], VEC[v][63:0]);
        end

        // R11 initialize, then control word fields
        do_cmd(INIT, 3'd0, 64'd0);
        do_cmd(STSW, 3'd0, 64'd0);
        do_cmd(LDCW, 3'd0, 64'h0A15);
        chk(round_mode == 2'd2 && exc_mask == 6'h15, "R9 field decode",
            64'({round_mode, exc_mask}), 64'({2'd2, 6'h15}));

        // R7 write then pop: result at ST(0) of the new top
        do_cmd(PUSH, 3'd0, 64'hAAAA);
        do_cmd(PUSH, 3'd0, 64'hBBBB);
        do_cmd(WRPOP, 3'd1, 64'hCCCC);
        do_cmd(READ, 3'd0, 64'd0);
        chk(rd_data == 64'hCCCC, "R7 result at ST0", rd_data, 64'hCCCC);
        do_cmd(WRPOP, 3'd0, 64'd0);
        do_cmd(WRPOP, 3'd0, 64'h1);
        do_cmd(STSW, 3'd0, 64'd0);
        chk(sw_data[6] && !sw_data[9], "R7 underflow bits", 64'(sw_data), 64'h0040);

        // R8 status load places TOP, push moves it; fault cleared
        do_cmd(LDSW, 3'd0, 64'h2800);
        do_cmd(PUSH, 3'd0, 64'h77);
        do_cmd(STSW, 3'd0, 64'd0);
        chk(sw_data == 16'h2000, "R8 top field", 64'(sw_data), 64'h2000);
        do_cmd(READ, 3'd0, 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule